// File: doc/BRIEF.md
# Packed-Word SPI Transmit Engine

This block sends a byte stream out of an SPI controller port. The bytes sit in a local memory whose words are 12 bits wide. They are packed with no padding, so every two words carry three bytes and some bytes straddle a word boundary. A host loads the memory over a simple parallel register port, sets the word count and the serial clock divider, switches the memory into a read-out mode, and then writes a control value that starts the transfer.

During a transfer, nCS is held low. A width converter then walks the memory in rising address order and shifts every word out MSB first. The words run back to back as one continuous bit stream, so the receiving device sees the original bytes in order. The serial clock follows SPI mode 0: it idles low, MOSI changes on the falling edge, and the device samples on the rising edge. When the last bit has gone out, nCS returns high and a done flag is raised.

Top module: `pkspi_tx_top`

## Requirements
- R1: After reset, ncs is 1, sclk is 0, mosi is 0, done is 0 and busy is 0. The memory is in storage mode, and the divider holds DIV_RESET (50, which gives 1 MHz from a 100 MHz clock).
- R2: Bytes are packed as follows. Byte 3k fills bits 11:4 of word 2k. The upper nibble of byte 3k+1 fills bits 3:0 of word 2k, and its lower nibble fills bits 11:8 of word 2k+1. Byte 3k+2 fills bits 7:0 of word 2k+1. Words are sent in order from address 0, each starting at bit 11, with no gap between words. The 12·LEN bits on MOSI therefore rebuild the byte sequence MSB first.
- R3: The mode register is reg_sel=0 and uses the low 8 bits of the written value. The value 0x84 selects storage mode and 0x8F selects read-out mode. Any other value leaves the mode unchanged. Mode writes are ignored while a transfer is active.
- R4: The control register is reg_sel=1. Bit 0 is chip select and bit 1 is write-start. A control write with both bits set starts a transfer only when all of these hold: the block is in read-out mode, the length is nonzero, and no transfer is running. In any other case ncs stays high.
- R5: A control write with bit 0 or bit 1 clear, made during a transfer, stops it at the next clock edge. At that edge ncs goes high and sclk goes low, and done stays 0.
- R6: The divider register is reg_sel=2. Each sclk half period lasts that many clock cycles, and a value of 0 acts as 1.
- R7: sclk is low whenever ncs is high. While ncs is low, mosi changes only on a falling sclk edge. The first bit is on mosi before the first rising edge.
- R8: The length register is reg_sel=3 and sets the number of words sent. After the falling sclk edge that ends the last bit, ncs goes high and done goes to 1 together. Any later control write clears done.
- R9: Memory writes (mem_we) take effect only in storage mode. Writes made in read-out mode, whether the block is idle or a transfer is active, are ignored.
- R10: The length register is ADDR_W bits wide, which caps it at DEPTH = 2^ADDR_W − 1 words. The largest length sends every word of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 control, 2 divider, 3 length |
| reg_wdata | input | REG_W | Register write value |
| mem_we | input | 1 | Memory word write strobe |
| mem_addr | input | ADDR_W | Memory word address |
| mem_wdata | input | WORD_W | Memory word value |
| ncs | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI serial clock (mode 0) |
| mosi | output | 1 | SPI serial data out |
| done | output | 1 | Last transfer completed |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case to reach is a word boundary in the middle of a byte, because the width converter must then fetch the next word with exactly the right timing. The stimulus reaches it by sweeping every length from one word to the full memory at several divider values, so every boundary offset and the final memory address are all crossed. The same sweep covers the case where the prefetched word arrives in the same cycle as the falling edge. Memory writes aimed at words not yet sent are placed mid-transfer, which shows that the stream uses the stored contents and not the late writes.

// File: rtl/pkspi_pkg.sv
package pkspi_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} xfer_st_t;

  localparam logic [7:0] MODE_STORE = 8'h84;
  localparam logic [7:0] MODE_READ  = 8'h8F;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;
  localparam logic [1:0] SEL_LEN  = 2'd3;
endpackage

// File: rtl/pkspi_wordmem.sv
module pkspi_wordmem #(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4095
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

  logic [WORD_W-1:0] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we && (waddr <= LAST_A)) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (raddr <= LAST_A) rdata <= store[raddr];
    else                 rdata <= '0;
  end
endmodule

// File: rtl/pkspi_tick.sv
module pkspi_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (half == '0) ? DIV_W'(1) : half;
    tick = run && (cnt == lim - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/pkspi_shifter.sv
module pkspi_shifter
  import pkspi_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              ctrl_wr,
  input  logic              tick,
  input  logic [ADDR_W-1:0] len,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              sclk,
  output logic              mosi,
  output logic              ncs,
  output logic              done,
  output logic              running
);
  localparam int BC_W = $clog2(WORD_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  xfer_st_t          st;
  logic [WORD_W-1:0] sh;
  logic [BC_W-1:0]   bcnt;
  logic [ADDR_W-1:0] widx;
  logic [ADDR_W-1:0] len_q;

  assign running = (st == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      sh    <= '0;
      bcnt  <= '0;
      widx  <= '0;
      len_q <= '0;
      raddr <= '0;
      sclk  <= 1'b0;
      mosi  <= 1'b0;
      ncs   <= 1'b1;
      done  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ctrl_wr) done <= 1'b0;
          if (start) begin
            st    <= ST_RUN;
            sh    <= rdata;
            mosi  <= rdata[WORD_W-1];
            bcnt  <= '0;
            widx  <= '0;
            len_q <= len;
            raddr <= ADDR_W'(1);
            ncs   <= 1'b0;
          end
        end
        default: begin
          if (abort) begin
            st    <= ST_IDLE;
            ncs   <= 1'b1;
            sclk  <= 1'b0;
            mosi  <= 1'b0;
            raddr <= '0;
          end else if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bcnt == LAST_BIT) begin
                if (widx == len_q - ADDR_W'(1)) begin
                  st    <= ST_IDLE;
                  ncs   <= 1'b1;
                  mosi  <= 1'b0;
                  done  <= 1'b1;
                  raddr <= '0;
                end else begin
                  sh    <= rdata;
                  mosi  <= rdata[WORD_W-1];
                  bcnt  <= '0;
                  widx  <= widx + ADDR_W'(1);
                  raddr <= raddr + ADDR_W'(1);
                end
              end else begin
                sh   <= sh << 1;
                mosi <= sh[WORD_W-2];
                bcnt <= bcnt + BC_W'(1);
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pkspi_tx_top.sv
module pkspi_tx_top
  import pkspi_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int ADDR_W    = 12,
  parameter int DEPTH     = 2**ADDR_W - 1,
  parameter int REG_W     = 16,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_wdata,
  output logic              ncs,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic              busy
);
  logic              mode_ro;
  logic [DIV_W-1:0]  div_q;
  logic [ADDR_W-1:0] len_q;
  logic              ctrl_wr, go_req, start, abort, tick, running;
  logic              store_ok;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rdata;

  assign busy     = running;
  assign ctrl_wr  = reg_we && (reg_sel == SEL_CTRL);
  assign go_req   = (reg_wdata[1:0] == 2'b11);
  assign start    = ctrl_wr && go_req && mode_ro && (len_q != '0) && !running;
  assign abort    = ctrl_wr && !go_req && running;
  assign store_ok = mem_we && !mode_ro && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_ro <= 1'b0;
      div_q   <= DIV_W'(DIV_RESET);
      len_q   <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_MODE: if (!running) begin
          if (reg_wdata[7:0] == MODE_STORE)     mode_ro <= 1'b0;
          else if (reg_wdata[7:0] == MODE_READ) mode_ro <= 1'b1;
        end
        SEL_DIV:  div_q <= reg_wdata[DIV_W-1:0];
        SEL_LEN:  len_q <= reg_wdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  pkspi_wordmem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .we(store_ok), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  pkspi_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .run(running), .half(div_q), .tick(tick)
  );

  pkspi_shifter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) shf_i (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .ctrl_wr(ctrl_wr),
    .tick(tick), .len(len_q), .rdata(rdata), .raddr(raddr),
    .sclk(sclk), .mosi(mosi), .ncs(ncs), .done(done), .running(running)
  );
endmodule

// File: rtl/pkspi_tx_chk.sv
module pkspi_tx_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [1:0]       reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic             ncs,
  input logic             sclk,
  input logic             mosi,
  input logic             done,
  input logic             mode_ro
);
  // R7: clock parked low outside a transfer
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    ncs |-> !sclk);

  // R7: data moves only with a falling clock edge
  a_r7_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!ncs && $past(!ncs) && !$fell(sclk)) |-> $stable(mosi));

  // R4: a transfer runs only in read-out mode
  a_r4_readout_only: assert property (@(posedge clk) disable iff (rst)
    !ncs |-> mode_ro);

  // R8: done never overlaps an active chip select
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> ncs);

  // R5: a stop request ends the transfer at the next edge without done
  a_r5_stop: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd1 && reg_wdata[1:0] != 2'b11 && !ncs)
      |=> (ncs && !sclk && !done));
endmodule

bind pkspi_tx_top pkspi_tx_chk #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .ncs(ncs), .sclk(sclk), .mosi(mosi),
  .done(done), .mode_ro(mode_ro)
);

// File: tb/pkspi_tx_top_tb_top.sv
`timescale 1ns/1ps
module pkspi_tx_top_tb_top;
  localparam int WORD_W = 12;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 2**ADDR_W - 1;
  localparam int REG_W  = 16;
  localparam int MAXB   = DEPTH * WORD_W;
  localparam int NBYTES = (MAXB + 7) / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [WORD_W-1:0] mem_wdata = '0;
  logic ncs, sclk, mosi, done, busy;

  always #4 clk = ~clk;

  pkspi_tx_top #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .ncs(ncs), .sclk(sclk), .mosi(mosi),
    .done(done), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  logic got [0:MAXB-1];
  int nbits = 0, last_rise = -1, per_bad = 0, exp_half = 1;
  logic prev_ncs = 1'b1, prev_sclk = 1'b0;
  logic [7:0] bytes [0:NBYTES-1];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!ncs && prev_ncs) begin
      nbits = 0; last_rise = -1; per_bad = 0;
    end
    if (!ncs && sclk && !prev_sclk) begin
      if (nbits < MAXB) got[nbits] = mosi;
      nbits++;
      if (last_rise >= 0 && (cyc - last_rise) != 2 * exp_half) per_bad++;
      last_rise = cyc;
    end
    prev_ncs = ncs;
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic reg_wr(input logic [1:0] s, input int v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = REG_W'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic mem_wr(input int a, input int d);
    @(negedge clk);
    mem_we = 1'b1; mem_addr = ADDR_W'(a); mem_wdata = WORD_W'(d);
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  function automatic int packed_word(input int w);
    int k = w / 2;
    if (w % 2 == 0) return {bytes[3*k], bytes[3*k+1][7:4]};
    else            return {bytes[3*k+1][3:0], bytes[3*k+2]};
  endfunction

  // R2 R6 R8 R9 R10: load, send, compare the stream to the byte sequence
  task automatic run_xfer(input int len, input int div, input int seed, input bit poke);
    int bad = 0;
    for (int i = 0; i < NBYTES; i++) bytes[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
    reg_wr(2'd0, 8'h84);
    for (int w = 0; w < len; w++) mem_wr(w, packed_word(w));
    if (div >= 0) reg_wr(2'd2, div);
    exp_half = (div < 0) ? 50 : ((div == 0) ? 1 : div);
    reg_wr(2'd3, len);
    reg_wr(2'd0, 8'h8F);
    if (poke) mem_wr(0, ~packed_word(0));   // R9: ignored in read-out mode
    reg_wr(2'd1, 3);
    if (poke && len > 1) begin
      repeat (3) @(negedge clk);
      mem_wr(len - 1, ~packed_word(len - 1));  // R9: ignored while active
    end
    for (int t = 0; t < 40000 && !done; t++) @(negedge clk);
    check(nbits == 12 * len, "R2 bit count", nbits, 12 * len);
    for (int j = 0; j < 12 * len && j < MAXB; j++)
      if (got[j] !== bytes[j / 8][7 - (j % 8)]) bad++;
    check(bad == 0, poke ? "R9 stream unchanged" : "R2 stream order", bad, 0);
    check(per_bad == 0, "R6 half period", per_bad, 0);
    check(done === 1'b1 && ncs === 1'b1, "R8 done with ncs high", {done, ncs}, 3);
    reg_wr(2'd1, 0);
    check(done === 1'b0, "R8 done cleared", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ncs === 1 && sclk === 0 && mosi === 0 && done === 0 && busy === 0,
          "R1 reset outputs", {ncs, sclk, mosi, done, busy}, 5'b10000);

    // R4: start refused in storage mode (after reset)
    mem_wr(0, 12'hABC);
    reg_wr(2'd3, 1);
    reg_wr(2'd1, 3);
    repeat (40) @(negedge clk);
    check(ncs === 1'b1, "R4 no start in storage mode", ncs, 1);
    reg_wr(2'd1, 0);

    // R1 R6: default divider on one word
    run_xfer(1, -1, 1, 0);
    run_xfer(2, 0, 2, 0);

    // R2 R10: sweep every length up to full memory at several dividers
    for (int d = 1; d <= 3; d++)
      for (int l = 1; l <= DEPTH; l++) run_xfer(l, d, l + 17 * d, 0);

    // R9: writes ignored in read-out mode and while active
    run_xfer(DEPTH, 2, 99, 1);
    run_xfer(4, 1, 7, 1);

    // R3: unknown mode code keeps read-out mode; start still accepted
    reg_wr(2'd0, 8'h55);
    reg_wr(2'd3, 2);
    reg_wr(2'd1, 3);
    @(negedge clk);
    check(ncs === 1'b0, "R3 unknown code keeps mode", ncs, 0);
    // R3: mode write ignored while active, R5 stop
    reg_wr(2'd0, 8'h84);
    repeat (5) @(negedge clk);
    check(ncs === 1'b0, "R3 mode write ignored when active", ncs, 0);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0;
    check(ncs === 1 && sclk === 0 && done === 0, "R5 stop", {ncs, sclk, done}, 3'b100);
    repeat (60) @(negedge clk);
    check(done === 1'b0 && ncs === 1'b1, "R5 stays stopped", {done, ncs}, 1);

    // R4: length zero refuses start
    reg_wr(2'd3, 0);
    reg_wr(2'd1, 3);
    repeat (20) @(negedge clk);
    check(ncs === 1'b1, "R4 zero length", ncs, 1);
    reg_wr(2'd1, 0);

    // R4: only one control bit set does not start
    reg_wr(2'd3, 1);
    reg_wr(2'd1, 1);
    repeat (20) @(negedge clk);
    check(ncs === 1'b1, "R4 single bit", ncs, 1);

    // R3: 0x84 returns to storage mode, so start is refused
    reg_wr(2'd0, 8'h84);
    reg_wr(2'd1, 3);
    repeat (20) @(negedge clk);
    check(ncs === 1'b1, "R3 storage code", ncs, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule